// File: doc/BRIEF.md
# Burst Column Address Counter

This block holds the column half of a DRAM address for a memory controller and moves it forward during page and burst accesses. An access begins when the address strobe rises while chip select is high. At that point the block either captures the incoming column address or keeps the value it already holds. It also decides whether the access is a burst by sampling a burst-request input. The active level of that input is set by configuration.

While a burst is running, each advance pulse from the acknowledge logic moves the column forward by one. The step is either linear across the whole column range or wrapped inside an aligned block of `BURST_LEN` columns. When a linear step carries out of the top column bit, the block raises a one-cycle page-crossing flag so the controller can open a new row. When latch mode is off and no burst is running, the column register simply follows the input one cycle late.

Top module: `burst_col_counter`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `col_out` = 0, `burst_active` = 0 and `page_cross` = 0.
- R2: An access start is a cycle in which `strobe` is 1, `strobe` was 0 in the previous cycle, and `chip_sel` is 1. At a start with `cfg_latch_en` = 1 and `latch_hold` = 0, `col_out` equals the sampled `col_in` one cycle later.
- R3: At a start with `cfg_latch_en` = 1 and `latch_hold` = 1, `col_out` keeps its value, and an advance in that same cycle is ignored.
- R4: A rising `strobe` while `chip_sel` = 0 is not a start. It neither loads the column nor sets `burst_active`.
- R5: With `cfg_latch_en` = 0 and no burst active, the cycle after any non-start cycle shows the `col_in` value that was sampled (a start also loads `col_in`).
- R6: At a start, `burst_active` becomes 1 when `burst_req` is at its active level, and 0 otherwise. `cfg_burst_pol` = 1 selects active-high and 0 selects active-low.
- R7: With `burst_active` = 1, `burst_req` active and `adv` = 1 in a non-start cycle, and `linear_en` = 1, `col_out` becomes its previous value plus one, modulo 2^COL_W.
- R8: Under the same advance conditions with `linear_en` = 0, the low log2(BURST_LEN) bits (bits 1:0 by default) increment modulo BURST_LEN and the upper bits are unchanged.
- R9: `page_cross` is 1 for exactly the one cycle after a linear advance from the all-ones column. That cycle shows `col_out` = 0. A wrapped advance never raises it.
- R10: When `burst_active` = 1 and `burst_req` is inactive in a non-start cycle, `burst_active` drops the next cycle, and an `adv` in that cycle leaves `col_out` unchanged.
- R11: With `cfg_latch_en` = 1 and no burst active, `adv` and changes on `col_in` have no effect on `col_out` outside a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_latch_en | input | 1 | 1: capture column only at access start; 0: track input when idle |
| cfg_burst_pol | input | 1 | 1: burst request active high; 0: active low |
| col_in | input | COL_W | Column address from the requester |
| strobe | input | 1 | Address strobe; rising edge starts an access |
| chip_sel | input | 1 | Qualifies the strobe |
| latch_hold | input | 1 | Suppresses column capture at this start |
| linear_en | input | 1 | 1: linear increment; 0: wrap within burst block |
| burst_req | input | 1 | Burst request, polarity set by `cfg_burst_pol` |
| adv | input | 1 | Advance pulse from acknowledge logic |
| col_out | output | COL_W | Current column address |
| burst_active | output | 1 | Burst in progress |
| page_cross | output | 1 | One-cycle flag on a linear carry out of the top bit |

## Verification
The assertions assume that the configuration inputs `cfg_latch_en` and `cfg_burst_pol` stay steady while a burst is in progress, and that `adv` is a single-cycle pulse as an acknowledge path would produce it. They also treat a start as overriding an advance in the same cycle. The random stimulus changes both configuration bits only between phases, after a reset. It holds chip select, strobe and burst request at biased probabilities so that bursts of useful length occur. Directed sequences place the column at the all-ones value and at the last entry of a wrap block, to reach the carry and roll-over cases.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
   typedef enum logic [1:0] {
      COL_HOLD  = 2'd0,
      COL_LOAD  = 2'd1,
      COL_STEP  = 2'd2,
      COL_TRACK = 2'd3
   } col_act_e;
endpackage

// File: rtl/bcc_access_ctl.sv
module bcc_access_ctl
   import bcc_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  logic     cfg_latch_en,
   input  logic     cfg_burst_pol,
   input  logic     strobe,
   input  logic     chip_sel,
   input  logic     latch_hold,
   input  logic     burst_req,
   input  logic     adv,
   output logic     start,
   output logic     burst_active,
   output col_act_e act
);
   logic strobe_q;
   logic req_act;

   assign req_act = cfg_burst_pol ? burst_req : ~burst_req;
   assign start   = strobe & ~strobe_q & chip_sel;

   always_ff @(posedge clk) begin
      if (rst) begin
         strobe_q     <= 1'b0;
         burst_active <= 1'b0;
      end else begin
         strobe_q <= strobe;
         if (start)
            burst_active <= req_act;
         else if (!req_act)
            burst_active <= 1'b0;
      end
   end

   always_comb begin
      if (start)
         act = (cfg_latch_en && latch_hold) ? COL_HOLD : COL_LOAD;
      else if (burst_active && !req_act)
         act = COL_HOLD;
      else if (burst_active && adv)
         act = COL_STEP;
      else if (!burst_active && !cfg_latch_en)
         act = COL_TRACK;
      else
         act = COL_HOLD;
   end

   // R6: burst state follows request level sampled at the start
   a_r6_burst_set: assert property (@(posedge clk) disable iff (rst)
      (start && req_act) |=> burst_active);
   a_r6_burst_clr: assert property (@(posedge clk) disable iff (rst)
      (start && !req_act) |=> !burst_active);
   // R4: a strobe without chip select does not open a burst
   a_r4_no_cs: assert property (@(posedge clk) disable iff (rst)
      (!chip_sel && !burst_active) |=> !burst_active);
   // R10: inactive request ends the burst
   a_r10_burst_end: assert property (@(posedge clk) disable iff (rst)
      (burst_active && !req_act && !start) |=> !burst_active);
endmodule

// File: rtl/bcc_col_step.sv
module bcc_col_step #(
   parameter int COL_W     = 10,
   parameter int BURST_LEN = 4
) (
   input  logic [COL_W-1:0] col,
   input  logic             linear_en,
   output logic [COL_W-1:0] nxt,
   output logic             crossing
);
   localparam int WRAP_W = $clog2(BURST_LEN);

   logic [COL_W:0]   sum;
   logic [COL_W-1:0] wrapped;

   assign sum = {1'b0, col} + (COL_W+1)'(1);

   generate
      if (WRAP_W == COL_W) begin : g_wrap_full
         assign wrapped = sum[COL_W-1:0];
      end else begin : g_wrap_part
         assign wrapped = {col[COL_W-1:WRAP_W], sum[WRAP_W-1:0]};
      end
   endgenerate

   assign nxt      = linear_en ? sum[COL_W-1:0] : wrapped;
   assign crossing = linear_en & sum[COL_W];
endmodule

// File: rtl/burst_col_counter.sv
module burst_col_counter
   import bcc_pkg::*;
#(
   parameter int COL_W     = 10,
   parameter int BURST_LEN = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cfg_latch_en,
   input  logic             cfg_burst_pol,
   input  logic [COL_W-1:0] col_in,
   input  logic             strobe,
   input  logic             chip_sel,
   input  logic             latch_hold,
   input  logic             linear_en,
   input  logic             burst_req,
   input  logic             adv,
   output logic [COL_W-1:0] col_out,
   output logic             burst_active,
   output logic             page_cross
);
   localparam int WRAP_W = $clog2(BURST_LEN);

   generate
      if (COL_W < 2) begin : g_chk_w
         $error("COL_W must be at least 2");
      end
      if (BURST_LEN < 2 || (1 << WRAP_W) != BURST_LEN) begin : g_chk_bl
         $error("BURST_LEN must be a power of two, at least 2");
      end
      if (WRAP_W > COL_W) begin : g_chk_fit
         $error("BURST_LEN exceeds column range");
      end
   endgenerate

   col_act_e         act;
   logic             start;
   logic [COL_W-1:0] col_q;
   logic [COL_W-1:0] col_nxt;
   logic             crossing;

   bcc_access_ctl u_ctl (
      .clk          (clk),
      .rst          (rst),
      .cfg_latch_en (cfg_latch_en),
      .cfg_burst_pol(cfg_burst_pol),
      .strobe       (strobe),
      .chip_sel     (chip_sel),
      .latch_hold   (latch_hold),
      .burst_req    (burst_req),
      .adv          (adv),
      .start        (start),
      .burst_active (burst_active),
      .act          (act)
   );

   bcc_col_step #(.COL_W(COL_W), .BURST_LEN(BURST_LEN)) u_step (
      .col      (col_q),
      .linear_en(linear_en),
      .nxt      (col_nxt),
      .crossing (crossing)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         col_q      <= '0;
         page_cross <= 1'b0;
      end else begin
         page_cross <= 1'b0;
         unique case (act)
            COL_LOAD, COL_TRACK: col_q <= col_in;
            COL_STEP: begin
               col_q      <= col_nxt;
               page_cross <= crossing;
            end
            default: col_q <= col_q;
         endcase
      end
   end

   assign col_out = col_q;

   // R1: reset clears column and flag
   a_r1_reset_clear: assert property (@(posedge clk)
      rst |=> (col_out == '0 && !page_cross && !burst_active));
   // R2: capture at start in latch mode
   a_r2_capture: assert property (@(posedge clk) disable iff (rst)
      (start && cfg_latch_en && !latch_hold) |=> col_out == $past(col_in));
   // R3: latch-disable keeps the column
   a_r3_hold_at_start: assert property (@(posedge clk) disable iff (rst)
      (start && cfg_latch_en && latch_hold) |=> $stable(col_out));
   // R7: linear advance
   a_r7_linear_step: assert property (@(posedge clk) disable iff (rst)
      (!start && act == COL_STEP && linear_en)
         |=> col_out == $past(col_out) + COL_W'(1));
   // R8: wrapped advance keeps the upper bits
   a_r8_wrap_upper: assert property (@(posedge clk) disable iff (rst)
      (!start && act == COL_STEP && !linear_en)
         |=> (col_out >> WRAP_W) == ($past(col_out) >> WRAP_W));
   // R9: page flag lasts one cycle and lands on column zero
   a_r9_cross_pulse: assert property (@(posedge clk) disable iff (rst)
      page_cross |=> !page_cross);
   a_r9_cross_zero: assert property (@(posedge clk) disable iff (rst)
      page_cross |-> col_out == '0);
   // R11: idle latch mode ignores advance and input changes
   a_r11_idle_stable: assert property (@(posedge clk) disable iff (rst)
      (!start && !burst_active && cfg_latch_en) |=> $stable(col_out));
endmodule

// File: tb/burst_col_counter_test.sv
module burst_col_counter_test;
   localparam int CLK_PERIOD = 10;
   localparam int COL_W      = 10;
   localparam int BURST_LEN  = 4;
   localparam int WMASK      = BURST_LEN - 1;

   logic             clk = 1'b0;
   logic             rst;
   logic             cfg_latch_en, cfg_burst_pol;
   logic [COL_W-1:0] col_in;
   logic             strobe, chip_sel, latch_hold, linear_en, burst_req, adv;
   logic [COL_W-1:0] col_out;
   logic             burst_active, page_cross;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   logic [COL_W-1:0] m_col;
   logic             m_ba, m_sp, m_pc;

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_col_counter #(.COL_W(COL_W), .BURST_LEN(BURST_LEN)) uut (
      .clk(clk), .rst(rst), .cfg_latch_en(cfg_latch_en), .cfg_burst_pol(cfg_burst_pol),
      .col_in(col_in), .strobe(strobe), .chip_sel(chip_sel), .latch_hold(latch_hold),
      .linear_en(linear_en), .burst_req(burst_req), .adv(adv),
      .col_out(col_out), .burst_active(burst_active), .page_cross(page_cross)
   );

   function automatic logic [COL_W-1:0] step_col(logic [COL_W-1:0] c, logic lin);
      if (lin) return c + COL_W'(1);
      return (c & ~COL_W'(WMASK)) | ((c + COL_W'(1)) & COL_W'(WMASK));
   endfunction

   // one clock: model the next state, then compare after the edge
   task automatic tick();
      string tag;
      logic req_act, st;
      req_act = cfg_burst_pol ? burst_req : ~burst_req;
      st = strobe & ~m_sp & chip_sel;
      if (rst) begin
         tag = "R1"; m_col = '0; m_ba = 0; m_pc = 0; m_sp = 0;
      end else begin
         m_pc = 0;
         if (st) begin
            if (cfg_latch_en && latch_hold) tag = "R3";
            else begin m_col = col_in; tag = cfg_latch_en ? "R2" : "R5"; end
            m_ba = req_act;
            if (!req_act) tag = {tag, "/R6"};
         end else if (m_ba && !req_act) begin
            tag = "R10"; m_ba = 0;
         end else if (m_ba && adv) begin
            m_pc  = linear_en && (m_col == '1);
            tag   = m_pc ? "R9" : (linear_en ? "R7" : "R8");
            m_col = step_col(m_col, linear_en);
         end else if (!m_ba && !cfg_latch_en) begin
            tag = "R5"; m_col = col_in;
         end else begin
            tag = (strobe && !m_sp && !chip_sel) ? "R4" : "R11";
         end
         m_sp = strobe;
      end
      @(posedge clk);
      #1;
      n_checks++;
      if (col_out !== m_col || burst_active !== m_ba || page_cross !== m_pc) begin
         n_fail++;
         $display("FAIL %s: col=%h ba=%b pc=%b expected col=%h ba=%b pc=%b",
                  tag, col_out, burst_active, page_cross, m_col, m_ba, m_pc);
      end
   endtask

   task automatic idle();
      strobe = 0; chip_sel = 0; latch_hold = 0; adv = 0; linear_en = 1;
   endtask

   task automatic start_burst(logic [COL_W-1:0] c, logic lin);
      col_in = c; strobe = 1; chip_sel = 1; latch_hold = 0; adv = 0;
      linear_en = lin; burst_req = cfg_burst_pol;
      tick();                                         // R2 / R6
      strobe = 0;
   endtask

   initial begin
      int unused;
      unused = $urandom(32'd1234);
      rst = 1; cfg_latch_en = 1; cfg_burst_pol = 1; col_in = '0; burst_req = 0;
      idle();
      @(posedge clk); #1;
      tick(); tick();                                 // R1 reset state
      rst = 0;

      // R9: linear carry out of the all-ones column
      start_burst('1, 1'b1);
      adv = 1; tick(); adv = 0; tick();               // R9 pulse then clear
      // R8: wrap from last entry of a block
      start_burst(COL_W'(10'h107), 1'b0);
      adv = 1; tick(); tick(); adv = 0;               // R8: 104, 105
      // R10: request drops, advance ignored
      burst_req = ~cfg_burst_pol; adv = 1; tick(); adv = 0; tick();
      // R3: latch hold keeps column
      col_in = COL_W'(10'h2AA); strobe = 1; chip_sel = 1; latch_hold = 1; tick();
      idle(); tick();
      // R4: strobe without chip select
      col_in = COL_W'(10'h055); strobe = 1; burst_req = cfg_burst_pol; tick();
      idle(); adv = 1; tick(); adv = 0;               // R11

      // random phases with all configuration combinations
      for (int ph = 0; ph < 8; ph++) begin
         rst = 1; tick(); rst = 0;
         cfg_latch_en  = ph[0];
         cfg_burst_pol = ph[1];
         for (int i = 0; i < 1500; i++) begin
            col_in     = COL_W'($urandom);
            if (ph[2] && ($urandom % 16 == 0)) col_in = '1;
            strobe     = ($urandom % 4) == 0;
            chip_sel   = ($urandom % 4) != 0;
            latch_hold = ($urandom % 5) == 0;
            linear_en  = ($urandom % 2) == 0;
            burst_req  = (($urandom % 10) != 0) ? cfg_burst_pol : ~cfg_burst_pol;
            adv        = ($urandom % 2) == 0;
            tick();
         end
      end
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule